// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a shared multiplexed address/data bus with one even-parity bit. The bus carries 32 address/data lines and a 4-bit command/byte-enable field. When the local device owns the AD lines, the block computes parity over the AD and command/byte-enable lines. It puts that bit on the parity line in the following clock and enables the parity driver for that clock only.

When another agent drives the bus, the block computes its own parity over every valid transfer. A valid transfer is an address phase, or a data phase in which both the initiator-ready and target-ready inputs are high. In the next clock it compares that result with the parity bit received on the bus. A mismatch is only reported; nothing is retried or corrected. A mismatch on an address phase raises a system-error pulse. A mismatch on a data phase raises a data-parity-error pulse, and only when that report is enabled. Every mismatch also sets a sticky error flag, which stays set until a clear input removes it.

The external reset is asynchronous and active low. Inside the block its release is synchronised over two flops.

Top module: `bus_parity_unit`

## Requirements
- R1: Parity is even over all 32 AD bits and all 4 command/byte-enable bits, so the XOR of those 36 bits and the parity bit is 0.
- R2: When `ad_drive_i` is high in clock N, `par_oe_o` is high in clock N+1 and `par_o` holds the parity of the AD/command values of clock N.
- R3: When `ad_drive_i` is low in clock N, `par_oe_o` is low in clock N+1.
- R4: A check is armed only when `ad_drive_i` is low and the clock is a valid transfer (`addr_phase_i` high, or both `init_rdy_i` and `tgt_rdy_i` high). Without one, no error output and no sticky flag is raised, whatever `par_i` carries.
- R5: An armed address-phase check whose `par_i` in clock N+1 differs from the computed parity raises `sys_err_o` in clock N+2, for exactly one clock.
- R6: An armed data-phase check with a mismatch raises `dperr_o` in clock N+2, for one clock, when `dperr_en_i` is high in clock N+1.
- R7: When `dperr_en_i` is low in clock N+1, a data-phase mismatch leaves `dperr_o` low but still sets `err_sticky_o`.
- R8: Any detected mismatch sets `err_sticky_o` in clock N+2. The flag stays set until `err_clr_i` is high in a clock with no new mismatch. A clear and a mismatch in the same clock leave it set.
- R9: While reset is active, `par_o`, `par_oe_o`, `sys_err_o`, `dperr_o` and `err_sticky_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_i | input | 4 | Command/byte-enable lines as seen on the bus |
| ad_drive_i | input | 1 | Local device drives AD and command lines this clock |
| addr_phase_i | input | 1 | Current clock is an address phase |
| init_rdy_i | input | 1 | Initiator ready |
| tgt_rdy_i | input | 1 | Target ready |
| par_i | input | 1 | Parity line as received |
| dperr_en_i | input | 1 | Enables data-phase error reporting |
| err_clr_i | input | 1 | Clears the sticky error flag |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for the parity driver |
| sys_err_o | output | 1 | One-clock pulse on an address-phase parity error |
| dperr_o | output | 1 | One-clock pulse on a data-phase parity error |
| err_sticky_o | output | 1 | Sticky record of any parity error |

## Verification
Two functions can meet in one clock: the capture of a fresh mismatch into the sticky flag, and a clear request from software. The bench provokes this by raising `err_clr_i` in the same clock as a wrong `par_i` on an armed phase. It also sweeps every other mix of clear, enable, phase kind and parity polarity. A bench-side model of the flag judges each case, and it expects the flag still set after a collision and cleared after a lone clear. The same sweep runs ready combinations that must not arm a check, and phases the device drives itself, to show that a wrong parity bit then leaves every output quiet.

// File: rtl/bpar_pkg.sv
`timescale 1ns/1ps
package bpar_pkg;

  // Kind of transfer captured for checking in the following clock
  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/bpar_calc.sv
`timescale 1ns/1ps
module bpar_calc #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  output logic              par_o
);
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  logic [LANES-1:0] lane_par;

  // one XOR tree per byte lane, folded together with the command field
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^ad_i[g*LANE_W +: LANE_W];
  end

  assign par_o = (^lane_par) ^ (^cbe_i);

endmodule

// File: rtl/bpar_gen.sv
`timescale 1ns/1ps
module bpar_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  input  logic calc_par_i,
  output logic par_o,
  output logic par_oe_o
);
  logic par_q, par_d;
  logic oe_q, oe_d;

  always_comb begin
    par_d = par_q;
    if (drive_i) par_d = calc_par_i;   // load only while local device owns AD
    oe_d  = drive_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  // R2: parity driver follows ownership of AD by one clock
  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> par_oe_o);

  // R3: driver released the clock after ownership ends
  p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> !par_oe_o);

endmodule

// File: rtl/bpar_chk.sv
`timescale 1ns/1ps
module bpar_chk
  import bpar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  input  logic addr_i,
  input  logic irdy_i,
  input  logic trdy_i,
  input  logic calc_par_i,
  input  logic par_i,
  input  logic dperr_en_i,
  input  logic err_clr_i,
  output logic sys_err_o,
  output logic dperr_o,
  output logic sticky_o
);
  logic   arm_d, arm_q;
  logic   exp_d, exp_q;
  phase_e kind_d, kind_q;
  logic   mismatch;
  logic   serr_d, serr_q;
  logic   dperr_d, dperr_q;
  logic   stk_d, stk_q;
  logic   xfer;

  // stage 1: capture expected parity of a foreign valid transfer
  always_comb begin
    xfer   = !drive_i && (addr_i || (irdy_i && trdy_i));
    arm_d  = xfer;
    exp_d  = exp_q;
    kind_d = kind_q;
    if (xfer) begin
      exp_d  = calc_par_i;
      kind_d = addr_i ? PH_ADDR : PH_DATA;
    end
  end

  // stage 2: compare with the received bit and grade the result
  always_comb begin
    mismatch = arm_q && (par_i != exp_q);
    serr_d   = mismatch && (kind_q == PH_ADDR);
    dperr_d  = mismatch && (kind_q == PH_DATA) && dperr_en_i;
    stk_d    = mismatch || (stk_q && !err_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      exp_q   <= 1'b0;
      kind_q  <= PH_NONE;
      serr_q  <= 1'b0;
      dperr_q <= 1'b0;
      stk_q   <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      exp_q   <= exp_d;
      kind_q  <= kind_d;
      serr_q  <= serr_d;
      dperr_q <= dperr_d;
      stk_q   <= stk_d;
    end
  end

  assign sys_err_o = serr_q;
  assign dperr_o   = dperr_q;
  assign sticky_o  = stk_q;

  // R4: no report without an armed check in the clock before
  p_quiet_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm_q) |-> (!sys_err_o && !dperr_o));

  // R5: system error only follows an armed address-phase check
  p_serr_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_o |-> $past(kind_q == PH_ADDR));

  // R6: data error report gated by the enable
  p_dperr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dperr_o |-> $past(dperr_en_i));

  // R8: every reported error is recorded
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_err_o || dperr_o) |-> sticky_o);

  // R8: flag holds while no clear is requested
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !err_clr_i) |=> sticky_o);

endmodule

// File: rtl/bus_parity_unit.sv
`timescale 1ns/1ps
module bus_parity_unit #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  input  logic              ad_drive_i,
  input  logic              addr_phase_i,
  input  logic              init_rdy_i,
  input  logic              tgt_rdy_i,
  input  logic              par_i,
  input  logic              dperr_en_i,
  input  logic              err_clr_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              sys_err_o,
  output logic              dperr_o,
  output logic              err_sticky_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic                   calc_par;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  bpar_calc #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_calc (
    .ad_i  (ad_i),
    .cbe_i (cbe_i),
    .par_o (calc_par)
  );

  bpar_gen u_gen (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .drive_i    (ad_drive_i),
    .calc_par_i (calc_par),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  bpar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .drive_i    (ad_drive_i),
    .addr_i     (addr_phase_i),
    .irdy_i     (init_rdy_i),
    .trdy_i     (tgt_rdy_i),
    .calc_par_i (calc_par),
    .par_i      (par_i),
    .dperr_en_i (dperr_en_i),
    .err_clr_i  (err_clr_i),
    .sys_err_o  (sys_err_o),
    .dperr_o    (dperr_o),
    .sticky_o   (err_sticky_o)
  );

  // R1: driven bit makes the covered word even, judged from the bus inputs
  p_even_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    par_oe_o |-> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0));

  // R9: outputs quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (!sys_err_o && !dperr_o && !err_sticky_o && !par_oe_o);
    end
  end

endmodule

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] ad;
  logic [CW-1:0] cbe;
  logic          ad_drive, addr_phase, irdy, trdy, par_in, dperr_en, err_clr;
  logic          par_o, par_oe, sys_err, dperr, sticky;

  int checks = 0;
  int errors = 0;
  logic stk_m = 1'b0;

  always #10 clk = ~clk;

  bus_parity_unit #(.DATA_W(DW), .CBE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .ad_drive_i(ad_drive),
    .addr_phase_i(addr_phase), .init_rdy_i(irdy), .tgt_rdy_i(trdy),
    .par_i(par_in), .dperr_en_i(dperr_en), .err_clr_i(err_clr),
    .par_o(par_o), .par_oe_o(par_oe), .sys_err_o(sys_err), .dperr_o(dperr),
    .err_sticky_o(sticky)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << (i % 32));
  endfunction

  // k: 0 foreign address, 1 data both ready, 2 initiator only, 3 target only, 4 own address
  task automatic run_phase(input int k, input logic [31:0] a, input logic [3:0] c,
                           input bit bad, input bit en, input bit clr);
    bit valid;
    valid      = (k == 0) || (k == 1);
    ad         = a;
    cbe        = c;
    ad_drive   = (k == 4);
    addr_phase = (k == 0) || (k == 4);
    irdy       = (k == 1) || (k == 2);
    trdy       = (k == 1) || (k == 3);
    dperr_en   = en;
    err_clr    = 1'b0;
    par_in     = 1'b0;
    @(negedge clk);
    ad_drive   = 1'b0;
    addr_phase = 1'b0;
    irdy       = 1'b0;
    trdy       = 1'b0;
    ad         = ~a;
    par_in     = (^{a, c}) ^ bad;
    err_clr    = clr;
    @(negedge clk);
    err_clr    = 1'b0;
    par_in     = 1'b0;
    stk_m      = (valid && bad) || (stk_m && !clr);
    if (valid) begin
      check("R5 address error", sys_err, (k == 0) && bad);
      if (en) check("R6 data error enabled", dperr, (k == 1) && bad);
      else    check("R7 data error disabled", dperr, 1'b0);
    end else begin
      check("R4 unarmed sys_err", sys_err, 1'b0);
      check("R4 unarmed dperr", dperr, 1'b0);
    end
    if (!en && k == 1) check("R7 sticky without report", sticky, stk_m);
    else               check("R8 sticky", sticky, stk_m);
    @(negedge clk);
    check("R5 single-clock sys_err", sys_err, 1'b0);
    check("R6 single-clock dperr", dperr, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ad = '0; cbe = '0; ad_drive = 1'b0; addr_phase = 1'b0;
    irdy = 1'b0; trdy = 1'b0; par_in = 1'b0; dperr_en = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset par_o", par_o, 1'b0);
    check("R9 reset par_oe", par_oe, 1'b0);
    check("R9 reset sys_err", sys_err, 1'b0);
    check("R9 reset dperr", dperr, 1'b0);
    check("R9 reset sticky", sticky, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // generation sweep: walking bits, inverted walks, every command value
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a        = (32'h1 << (i % 32)) ^ ((i >= 32) ? 32'hFFFF_FFFF : 32'h0);
      ad       = a;
      cbe      = i[3:0];
      ad_drive = 1'b1;
      @(negedge clk);
      check("R1 even parity", par_o, ^{a, i[3:0]});
      check("R2 driver enabled", par_oe, 1'b1);
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a;
      a   = pattern(i);
      ad  = a;
      cbe = 4'(15 - i);
      @(negedge clk);
      check("R1 even parity mixed", {31'b0, par_o ^ (^{a, 4'(15 - i)})}, 32'h0);
    end
    ad_drive = 1'b0;
    ad       = 32'hA5A5_0F0F;
    @(negedge clk);
    check("R3 driver released", par_oe, 1'b0);
    @(negedge clk);
    check("R3 driver stays released", par_oe, 1'b0);

    // checking sweep, including clear colliding with a fresh error
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 5; k++) begin
        for (int m = 0; m < 8; m++) begin
          run_phase(k, pattern(p * 7 + k), 4'(p * 5 + k), m[0], m[1], m[2]);
        end
      end
    end

    // explicit collision, then a lone clear
    run_phase(0, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1, 1'b0);
    run_phase(1, 32'h0000_0000, 4'h0, 1'b1, 1'b1, 1'b1);
    check("R8 set wins over clear", sticky, 1'b1);
    run_phase(2, 32'h1234_5678, 4'h3, 1'b1, 1'b1, 1'b1);
    check("R8 clear alone", sticky, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule